// File: doc/BRIEF.md
# Synchronous Character-Sync Receiver

This block turns a synchronous serial bit stream, delivered one bit per strobe, into characters. After the receive enable is raised it searches the stream bit by bit for a programmed sync character. It can also require a second sync character to follow at once. Once locked, it cuts the stream into characters of 5 to 8 data bits, with an optional parity bit, and places them in a receive holding register for a host to read.

Between the framing logic and the holding register sits a filter. It can drop sync fill and link-escape (DLE) characters. It pairs them, so an escaped escape or a doubled sync still reaches the host as data. Status flags report sync detection, DLE detection, parity errors and overruns. A status-read strobe clears the flags, and a data-read strobe clears the ready flag.

Top module: `sync_char_rx`

## Requirements
- R1: Each 0-to-1 change of `rxEnable` starts a hunt. During the hunt, after every strobed bit, the last L received bits are compared with the low L bits of `syn1`. A match is found at any bit phase, including a pattern that starts in the middle of an earlier character.
- R2: With `singleSync`=1, a hunt match sets `syncDet` and locks the receiver. With `singleSync`=0, the next whole character must equal `syn2`; otherwise the block returns to hunting. The bit that ends the failed check is not compared again, so SYN1, SYN1, SYN2 does not lock.
- R3: The characters that establish sync are never loaded into the holding register. When parity is on, the bit after the hunted SYN1 is taken as its parity bit and skipped.
- R4: Once locked, each character that is not dropped is loaded into `holdData` and sets `ready`. `readStrobe` clears `ready`. A load while `ready` is still 1, without a read in the same cycle, sets `overrun`.
- R5: The character length L is 5 + `charLen` (00=5, 01=6, 10=7, 11=8). Bits arrive LSB first, and the holding register bits above L read as 0.
- R6: With `parityEn`=1, the bit after the last data bit is parity. `parityOdd`=0 expects an even count of ones over data and parity; `parityOdd`=1 expects an odd count. A mismatch sets `parityErr`.
- R7: In strip mode with `transparent`=0: in single-sync mode every SYN1 is dropped. In double-sync mode a SYN1 is dropped unless it is the second of a SYN1 SYN1 pair. A SYN2 is dropped only right after a dropped SYN1. With strip off, every character is delivered.
- R8: In strip mode with `transparent`=1, a DLE is dropped unless it is the second of a DLE DLE pair. A SYN1 is dropped only right after a dropped DLE.
- R9: After lock, `syncDet` is set by a SYN1 in normal single-sync mode, by a SYN1 then SYN2 in normal double-sync mode, and by a DLE then SYN1 in transparent mode. With `transparent`=1 and `parityEn`=0, `dleDet` is set by a DLE that is not the second of a pair. Stripping has no effect on either flag. `statusRead` clears `syncDet`, `dleDet`, `parityErr` and `overrun`.
- R10: `rxEnable`=0 stops the block at once. It discards the partial character and clears `ready`, `parityErr`, `overrun`, `syncDet` and `dleDet`. Strobed bits are ignored until the next rising enable starts a new hunt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitStrobe | input | 1 | One-cycle pulse qualifying `bitIn` |
| bitIn | input | 1 | Serial data bit |
| rxEnable | input | 1 | Receive enable; a rising change starts the hunt |
| charLen | input | 2 | Character length select, L = 5 + value |
| parityEn | input | 1 | Parity bit present |
| parityOdd | input | 1 | 1 = odd parity, 0 = even |
| singleSync | input | 1 | 1 = single sync character, 0 = SYN1 then SYN2 |
| transparent | input | 1 | DLE-escaped framing for stripping and detection |
| stripEn | input | 1 | Drop sync and DLE characters from delivered data |
| syn1 | input | MaxBits | First sync character |
| syn2 | input | MaxBits | Second sync character |
| dle | input | MaxBits | Link-escape character |
| readStrobe | input | 1 | Host read of the holding register |
| statusRead | input | 1 | Host read of the status flags |
| holdData | output | MaxBits | Receive holding register |
| ready | output | 1 | Holding register has an unread character |
| parityErr | output | 1 | Parity error seen |
| overrun | output | 1 | Character loaded over an unread one |
| syncDet | output | 1 | Sync sequence detected |
| dleDet | output | 1 | DLE received |

## Verification
The hardest states to reach from the ports are the paired-stripping decisions. Whether a SYN1, SYN2 or DLE is dropped depends on what the previous character was and whether that one was dropped. Each strip scenario therefore feeds long crafted sequences, such as escape, escape, SYN1, after a fresh lock, and checks every character boundary for load or no load. The failed double-sync case is built from a SYN1 value that cannot reappear in the bit windows spanning the SYN1, SYN2 and idle-ones stream. This proves that no hidden re-match occurs on the bit that ends the failed check.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HUNT,
    ST_SKIP,
    ST_PAIR,
    ST_SYNC
  } rxState_t;

  typedef struct packed {
    logic shiftEn;
    logic cntClr;
    logic loadHold;
  } rxStrobe_t;
endpackage

// File: rtl/sync_rx_datapath.sv
module sync_rx_datapath
  import sync_rx_pkg::*;
#(
  parameter int MaxBits = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  rxStrobe_t          strobe,
  input  logic               bitIn,
  input  logic [1:0]         charLen,
  input  logic               parityEn,
  input  logic               parityOdd,
  input  logic [MaxBits-1:0] syn1,
  input  logic [MaxBits-1:0] syn2,
  input  logic [MaxBits-1:0] dle,
  output logic               huntHit,
  output logic               charDone,
  output logic               isSyn1,
  output logic               isSyn2,
  output logic               isDle,
  output logic               parityBad,
  output logic [MaxBits-1:0] holdData
);
  localparam int ShW  = MaxBits + 1;
  localparam int CntW = $clog2(MaxBits + 1);

  logic [ShW-1:0]     shiftQ, shiftNxt;
  logic [CntW-1:0]    cntQ, lastIdx;
  logic [1:0]         padBits;
  logic [MaxBits-1:0] lenMask, dataWin, huntWin;

  always_comb begin
    shiftNxt = {bitIn, shiftQ[ShW-1:1]};
    padBits  = 2'd3 - charLen;
    lenMask  = {MaxBits{1'b1}} >> padBits;
    huntWin  = shiftNxt[ShW-1:1] >> padBits;
    dataWin  = (parityEn ? shiftNxt[MaxBits-1:0] : shiftNxt[ShW-1:1]) >> padBits;
    lastIdx  = CntW'(MaxBits - 4) + CntW'(charLen) + CntW'(parityEn);
    huntHit  = strobe.shiftEn && (huntWin == (syn1 & lenMask));
    charDone = strobe.shiftEn && (cntQ == lastIdx);
    isSyn1   = dataWin == (syn1 & lenMask);
    isSyn2   = dataWin == (syn2 & lenMask);
    isDle    = dataWin == (dle & lenMask);
    parityBad = parityEn && (((^dataWin) ^ shiftNxt[ShW-1]) != parityOdd);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ   <= '0;
      cntQ     <= '0;
      holdData <= '0;
    end else begin
      if (strobe.shiftEn) shiftQ <= shiftNxt;
      if (strobe.cntClr) cntQ <= '0;
      else if (strobe.shiftEn) cntQ <= (cntQ == lastIdx) ? '0 : cntQ + 1'b1;
      if (strobe.loadHold) holdData <= dataWin;
    end
  end
endmodule

// File: rtl/sync_rx_control.sv
module sync_rx_control
  import sync_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      bitStrobe,
  input  logic      rxEnable,
  input  logic      parityEn,
  input  logic      singleSync,
  input  logic      transparent,
  input  logic      stripEn,
  input  logic      readStrobe,
  input  logic      statusRead,
  input  logic      huntHit,
  input  logic      charDone,
  input  logic      isSyn1,
  input  logic      isSyn2,
  input  logic      isDle,
  input  logic      parityBad,
  output rxStrobe_t strobe,
  output rxState_t  rxState,
  output logic      ready,
  output logic      parityErr,
  output logic      overrun,
  output logic      syncDet,
  output logic      dleDet
);
  rxState_t stateNxt;
  logic enPrevQ, enRise, prevLeadQ;
  logic plainSingle, leadHit, followHit, leadFirst;
  logic charEvt, dropCh, syncAgain, dleSeen, gotSync, deliver;

  always_comb begin
    enRise      = rxEnable && !enPrevQ;
    plainSingle = !transparent && singleSync;
    leadHit     = transparent ? isDle : isSyn1;
    followHit   = transparent ? isSyn1 : isSyn2;
    leadFirst   = leadHit && !prevLeadQ;
    charEvt     = (rxState == ST_SYNC) && charDone;
    dropCh      = stripEn && (plainSingle ? isSyn1 : (leadFirst || (followHit && prevLeadQ)));
    syncAgain   = plainSingle ? isSyn1 : (followHit && prevLeadQ);
    dleSeen     = transparent && !parityEn && isDle && !prevLeadQ;
    gotSync     = ((rxState == ST_HUNT) && huntHit && singleSync) ||
                  ((rxState == ST_PAIR) && charDone && isSyn2);
    deliver     = charEvt && !dropCh;

    strobe.shiftEn  = bitStrobe && rxEnable && !enRise && (rxState != ST_IDLE);
    strobe.cntClr   = (rxState == ST_IDLE) || (rxState == ST_HUNT) || (rxState == ST_SKIP);
    strobe.loadHold = deliver;

    stateNxt = rxState;
    if (!rxEnable) stateNxt = ST_IDLE;
    else if (enRise) stateNxt = ST_HUNT;
    else begin
      case (rxState)
        ST_HUNT: if (huntHit)
                   stateNxt = parityEn ? ST_SKIP : (singleSync ? ST_SYNC : ST_PAIR);
        ST_SKIP: if (strobe.shiftEn) stateNxt = singleSync ? ST_SYNC : ST_PAIR;
        ST_PAIR: if (charDone) stateNxt = isSyn2 ? ST_SYNC : ST_HUNT;
        default: stateNxt = rxState;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState   <= ST_IDLE;
      enPrevQ   <= 1'b0;
      prevLeadQ <= 1'b0;
      ready     <= 1'b0;
      parityErr <= 1'b0;
      overrun   <= 1'b0;
      syncDet   <= 1'b0;
      dleDet    <= 1'b0;
    end else begin
      rxState <= stateNxt;
      enPrevQ <= rxEnable;
      if (rxState != ST_SYNC) prevLeadQ <= 1'b0;
      else if (charEvt) prevLeadQ <= leadFirst;
      if (!rxEnable) begin
        ready     <= 1'b0;
        parityErr <= 1'b0;
        overrun   <= 1'b0;
        syncDet   <= 1'b0;
        dleDet    <= 1'b0;
      end else begin
        if (deliver) ready <= 1'b1;
        else if (readStrobe) ready <= 1'b0;
        if (deliver && ready && !readStrobe) overrun <= 1'b1;
        else if (statusRead) overrun <= 1'b0;
        if (charEvt && parityBad) parityErr <= 1'b1;
        else if (statusRead) parityErr <= 1'b0;
        if (gotSync || (charEvt && syncAgain)) syncDet <= 1'b1;
        else if (statusRead) syncDet <= 1'b0;
        if (charEvt && dleSeen) dleDet <= 1'b1;
        else if (statusRead) dleDet <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sync_char_rx.sv
module sync_char_rx
  import sync_rx_pkg::*;
#(
  parameter int MaxBits = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               bitStrobe,
  input  logic               bitIn,
  input  logic               rxEnable,
  input  logic [1:0]         charLen,
  input  logic               parityEn,
  input  logic               parityOdd,
  input  logic               singleSync,
  input  logic               transparent,
  input  logic               stripEn,
  input  logic [MaxBits-1:0] syn1,
  input  logic [MaxBits-1:0] syn2,
  input  logic [MaxBits-1:0] dle,
  input  logic               readStrobe,
  input  logic               statusRead,
  output logic [MaxBits-1:0] holdData,
  output logic               ready,
  output logic               parityErr,
  output logic               overrun,
  output logic               syncDet,
  output logic               dleDet
);
  rxStrobe_t strobe;
  rxState_t  rxState;
  logic huntHit, charDone, isSyn1, isSyn2, isDle, parityBad;

  sync_rx_datapath #(.MaxBits(MaxBits)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .bitIn(bitIn), .charLen(charLen),
    .parityEn(parityEn), .parityOdd(parityOdd), .syn1(syn1), .syn2(syn2), .dle(dle),
    .huntHit(huntHit), .charDone(charDone), .isSyn1(isSyn1), .isSyn2(isSyn2),
    .isDle(isDle), .parityBad(parityBad), .holdData(holdData)
  );

  sync_rx_control uCtrl (
    .clk(clk), .rstN(rstN), .bitStrobe(bitStrobe), .rxEnable(rxEnable),
    .parityEn(parityEn), .singleSync(singleSync), .transparent(transparent),
    .stripEn(stripEn), .readStrobe(readStrobe), .statusRead(statusRead),
    .huntHit(huntHit), .charDone(charDone), .isSyn1(isSyn1), .isSyn2(isSyn2),
    .isDle(isDle), .parityBad(parityBad), .strobe(strobe), .rxState(rxState),
    .ready(ready), .parityErr(parityErr), .overrun(overrun), .syncDet(syncDet),
    .dleDet(dleDet)
  );
endmodule

// File: rtl/sync_rx_checker.sv
module sync_rx_checker
  import sync_rx_pkg::*;
#(
  parameter int MaxBits = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               rxEnable,
  input logic [1:0]         charLen,
  input logic               singleSync,
  input logic               transparent,
  input logic               stripEn,
  input logic [MaxBits-1:0] holdData,
  input logic               ready,
  input logic               parityErr,
  input logic               overrun,
  input logic               syncDet,
  input logic               dleDet,
  input rxState_t           rxState,
  input logic               huntHit,
  input logic               charDone,
  input logic               isSyn1
);
  assert_off_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> !ready && !parityErr && !overrun && !syncDet && !dleDet);

  assert_ready_on_char_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> $past(charDone));

  assert_overrun_needs_ready_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(ready));

  assert_no_load_before_lock_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> $past(rxState) == ST_SYNC);

  assert_hunt_sync_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncDet) && ($past(rxState) == ST_HUNT) |-> $past(huntHit) && $past(singleSync));

  assert_upper_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> ((holdData >> (MaxBits - 3 + int'($past(charLen)))) == '0));

  assert_single_strip_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rxState == ST_SYNC) && charDone && stripEn && !transparent && singleSync && isSyn1
      |=> !$rose(ready) && $stable(holdData));
endmodule

bind sync_char_rx sync_rx_checker #(.MaxBits(MaxBits)) uChk (
  .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .charLen(charLen),
  .singleSync(singleSync), .transparent(transparent), .stripEn(stripEn),
  .holdData(holdData), .ready(ready), .parityErr(parityErr), .overrun(overrun),
  .syncDet(syncDet), .dleDet(dleDet), .rxState(rxState), .huntHit(huntHit),
  .charDone(charDone), .isSyn1(isSyn1)
);

// File: tb/tb_sync_char_rx.sv
module tb_sync_char_rx;
  localparam int ClkPeriod = 10;
  localparam logic [7:0] S1 = 8'h16;
  localparam logic [7:0] S2 = 8'hB5;
  localparam logic [7:0] DL = 8'h10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitStrobe = 0, bitIn = 1, rxEnable = 0;
  logic [1:0] charLen = 2'd3;
  logic parityEn = 0, parityOdd = 0, singleSync = 1, transparent = 0, stripEn = 0;
  logic readStrobe = 0, statusRead = 0;
  logic [7:0] holdData;
  logic ready, parityErr, overrun, syncDet, dleDet;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #(ClkPeriod/2) clk = ~clk;

  sync_char_rx dut (
    .clk(clk), .rstN(rstN), .bitStrobe(bitStrobe), .bitIn(bitIn), .rxEnable(rxEnable),
    .charLen(charLen), .parityEn(parityEn), .parityOdd(parityOdd), .singleSync(singleSync),
    .transparent(transparent), .stripEn(stripEn), .syn1(S1), .syn2(S2), .dle(DL),
    .readStrobe(readStrobe), .statusRead(statusRead), .holdData(holdData), .ready(ready),
    .parityErr(parityErr), .overrun(overrun), .syncDet(syncDet), .dleDet(dleDet)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sendBit(input logic b);
    @(negedge clk); bitIn = b; bitStrobe = 1;
    @(negedge clk); bitStrobe = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic sendChar(input logic [7:0] v, input bit badPar = 0);
    int len = 5 + int'(charLen);
    logic [7:0] m = 8'hFF >> (8 - len);
    for (int i = 0; i < len; i++) sendBit(v[i]);
    if (parityEn) sendBit((^(v & m)) ^ parityOdd ^ badPar);
  endtask

  task automatic pulseRead();
    @(negedge clk); readStrobe = 1;
    @(negedge clk); readStrobe = 0;
  endtask

  task automatic pulseStatus();
    @(negedge clk); statusRead = 1;
    @(negedge clk); statusRead = 0;
  endtask

  task automatic expectChar(input logic [7:0] v, input bit deliver, input string tag);
    sendChar(v);
    if (deliver) begin
      check(ready && holdData == v, tag, holdData, v);
      pulseRead();
    end else check(!ready, tag, ready, 0);
  endtask

  task automatic configure(input int len, input bit par, input bit odd, input bit single,
                           input bit transp, input bit strip);
    rxEnable = 0;
    charLen = 2'(len - 5); parityEn = par; parityOdd = odd;
    singleSync = single; transparent = transp; stripEn = strip;
    repeat (3) @(negedge clk);
    rxEnable = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic lockUp();
    for (int i = 0; i < 3; i++) sendBit(1'b1);
    sendChar(S1);
    if (!singleSync) sendChar(S2);
  endtask

  task automatic testReset();
    check(!ready && !parityErr && !overrun && !syncDet && !dleDet && holdData == 0,
          "reset R10", {ready, parityErr, overrun, syncDet, dleDet}, 0);
  endtask

  task automatic testSingleHunt();
    configure(8, 0, 0, 1, 0, 0);
    for (int i = 0; i < 3; i++) sendBit(1'b1);
    for (int i = 0; i < 7; i++) sendBit(S1[i]);
    check(!syncDet, "R1 no early match", syncDet, 0);
    sendBit(S1[7]);
    check(syncDet, "R1 R2 straddled SYN1 locks", syncDet, 1);
    check(!ready, "R3 sync char not loaded", ready, 0);
    pulseStatus();
    check(!syncDet, "R9 status read clears syncDet", syncDet, 0);
    expectChar(8'h41, 1, "R4 first char");
    expectChar(8'h5A, 1, "R4 second char");
    expectChar(S1, 1, "R7 strip off delivers SYN1");
    sendChar(8'h11);
    sendChar(8'h22);
    check(overrun && holdData == 8'h22, "R4 overrun", {overrun, holdData}, 9'h122);
    pulseRead();
  endtask

  task automatic testDouble();
    configure(8, 0, 0, 0, 0, 0);
    lockUp();
    check(syncDet && !ready, "R2 double lock", {syncDet, ready}, 2'b10);
    expectChar(8'h41, 1, "R2 data after double lock");
    configure(8, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) sendBit(1'b1);
    sendChar(S1); sendChar(S1); sendChar(S2);
    for (int i = 0; i < 8; i++) sendBit(1'b1);
    check(!syncDet && !ready, "R2 SYN1 SYN1 SYN2 no lock", {syncDet, ready}, 0);
    sendChar(S1); sendChar(S2);
    check(syncDet, "R2 retry locks", syncDet, 1);
  endtask

  task automatic testParityLen();
    configure(6, 1, 0, 1, 0, 0);
    lockUp();
    check(syncDet && !ready, "R3 parity lock", {syncDet, ready}, 2'b10);
    expectChar(8'h2B, 1, "R5 six-bit char");
    check(!parityErr, "R6 good parity", parityErr, 0);
    sendChar(8'h15, 1);
    check(parityErr && holdData == 8'h15, "R6 bad parity", {parityErr, holdData}, 9'h115);
    pulseRead();
    pulseStatus();
    check(!parityErr, "R9 parity cleared", parityErr, 0);
  endtask

  task automatic testStripSingle();
    configure(8, 0, 0, 1, 0, 1);
    lockUp();
    pulseStatus();
    expectChar(S1, 0, "R7 single SYN1 dropped");
    check(syncDet, "R9 stripped SYN1 sets syncDet", syncDet, 1);
    expectChar(8'h41, 1, "R7 data kept");
  endtask

  task automatic testStripDouble();
    configure(8, 0, 0, 0, 0, 1);
    lockUp();
    pulseStatus();
    expectChar(S1, 0, "R7 SYN1 dropped");
    expectChar(S2, 0, "R7 SYN2 after SYN1 dropped");
    check(syncDet, "R9 pair sets syncDet", syncDet, 1);
    expectChar(8'h41, 1, "R7 data kept");
    expectChar(S1, 0, "R7 first of pair dropped");
    expectChar(S1, 1, "R7 second of pair kept");
    expectChar(S2, 1, "R7 SYN2 after kept SYN1");
    expectChar(S2, 1, "R7 lone SYN2 kept");
  endtask

  task automatic testTransparent();
    configure(8, 0, 0, 0, 1, 1);
    lockUp();
    pulseStatus();
    expectChar(DL, 0, "R8 DLE dropped");
    check(dleDet, "R9 DLE detect", dleDet, 1);
    expectChar(8'h41, 1, "R8 data kept");
    pulseStatus();
    expectChar(DL, 0, "R8 DLE before SYN1 dropped");
    expectChar(S1, 0, "R8 SYN1 after DLE dropped");
    check(syncDet, "R9 DLE SYN1 sets syncDet", syncDet, 1);
    expectChar(DL, 0, "R8 first DLE of pair dropped");
    pulseStatus();
    expectChar(DL, 1, "R8 second DLE kept");
    check(!dleDet, "R9 second DLE no detect", dleDet, 0);
    expectChar(S1, 1, "R8 SYN1 after kept DLE");
  endtask

  task automatic testDisable();
    configure(8, 0, 0, 1, 0, 0);
    lockUp();
    sendChar(8'h41);
    sendChar(8'h5A);
    for (int i = 0; i < 4; i++) sendBit(1'b0);
    @(negedge clk); rxEnable = 0;
    repeat (2) @(negedge clk);
    check(!ready && !overrun && !syncDet, "R10 disable clears", {ready, overrun, syncDet}, 0);
    sendChar(S1);
    check(!syncDet && !ready, "R10 bits ignored while off", {syncDet, ready}, 0);
    rxEnable = 1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 8; i++) sendBit(1'b1);
    check(!ready && !syncDet, "R1 re-hunt no lock", {ready, syncDet}, 0);
    sendChar(S1);
    check(syncDet, "R1 re-hunt locks", syncDet, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testSingleHunt();
    testDouble();
    testParityLen();
    testStripSingle();
    testStripDouble();
    testTransparent();
    testDisable();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule